// File: doc/BRIEF.md
# Asynchronous Bytewide SRAM Bus Slave

This block lets an internal byte-wide memory array act as an ordinary asynchronous static RAM on a bus that has no clock of its own. The bus master drives three active-low strobes (select, output enable, write enable), an address and write data. The block samples the strobes with a fast system clock and turns them into read, write or idle activity. It also decides when the data drivers are switched on. A write window opens only while both select and write enable are low, and it closes as soon as either of them rises. The byte on the data bus at the closing clock is stored at the address that was present when the window opened.

A write-protect input from a supply supervisor blocks all bus activity while it is high. After each committed write, a recovery interval of a programmable number of system clocks must pass before the bus is served again. The interval is short but never zero-width in effect. The array depth is set by the address width parameter: 17 bits gives 131,072 bytes, and the default is smaller so that elaboration stays light. A sticky flag reports a master that changed the address while a write window was open. There is no limit on how many writes may be made.

Top module: `sram_bus_slave`

## Requirements
- R1: After reset, the driver enable `bus_doe` is 0, `addr_err` is 0 and `bus_dout` is 0.
- R2: With select low, output enable low, write enable high, no write protect and no recovery pending, `bus_doe` goes to 1 and `bus_dout` carries the byte stored at `bus_addr`. Strobes reach the logic through two synchronizing flops, so drivers turn on within four clocks.
- R3: A write window opens only while select and write enable are both low, so write enable pulsing with select high stores nothing. The stored byte is the value of `bus_din` on the clock where the window closes, not the value present when it opened.
- R4: The window closes at the first rising strobe. If select rises while write enable is still low, later changes on `bus_din` are not stored.
- R5: If write enable falls while the drivers are on, `bus_doe` returns to 0 within four clocks.
- R6: After a write commits, a window of `recov_clks` system clocks follows. During it, read requests leave `bus_doe` at 0 and write strobes store nothing.
- R7: While `wr_inhibit` is 1, `bus_doe` stays 0 and no byte is stored. A write window that is open when `wr_inhibit` rises is abandoned without storing.
- R8: If `bus_addr` differs from the address captured at window open while the window is open, `addr_err` becomes 1 and stays 1 until reset. The byte still goes to the captured address.
- R9: Any number of consecutive writes each store their byte. There is no wear limit or write counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system sampling clock |
| rst_n | input | 1 | asynchronous active-low reset |
| bus_ce_n | input | 1 | active-low chip select from the bus |
| bus_oe_n | input | 1 | active-low output enable from the bus |
| bus_we_n | input | 1 | active-low write enable from the bus |
| bus_addr | input | ADDR_W | byte address |
| bus_din | input | 8 | write data from the bus |
| bus_dout | output | 8 | read data toward the tri-state pads (0 while off) |
| bus_doe | output | 1 | enable for the data tri-state drivers |
| wr_inhibit | input | 1 | write protect from the supply supervisor, active high |
| recov_clks | input | 8 | recovery length after each write, in system clocks |
| addr_err | output | 1 | sticky flag: address moved during an open write window |

## Verification
Two pairs of functions can land on the same clock. The first pair is a read in progress and the start of a write. The bench holds select and output enable low with the drivers on and then pulls write enable low. It then checks that the drivers drop while the accidental write still stores the byte it carries. The second pair is a write window and write protect. The bench raises `wr_inhibit` inside an open window and, separately, holds a read or write request inside the recovery interval. It judges both cases by reading the location back once the bus is free again and by observing `bus_doe` during the blocked interval.

// File: rtl/sram_slv_pkg.sv
package sram_slv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_RECOV = 2'd2
  } slv_state_e;
endpackage

// File: rtl/sram_strobe_sync.sv
module sram_strobe_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;
    always_comb chain_d = {chain_q[STAGES-2:0], async_i[b]};
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= chain_d;
    end
    assign sync_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/sram_cycle_ctl.sv
module sram_cycle_ctl
  import sram_slv_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_s,
  input  logic              oe_s,
  input  logic              we_s,
  input  logic              inhibit,
  input  logic [CNT_W-1:0]  recov_clks,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              commit,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              drv_en,
  output logic              addr_err
);
  slv_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] wa_q, wa_d;
  logic              err_q, err_d;
  logic              drv_q, drv_d;
  logic              open_req;

  assign open_req = !ce_s && !we_s && !inhibit;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    wa_d    = wa_q;
    err_d   = err_q;
    commit  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (open_req) begin
          state_d = ST_WRITE;
          wa_d    = bus_addr;
        end
      end
      ST_WRITE: begin
        if (inhibit) begin
          state_d = ST_IDLE;
        end else if (ce_s || we_s) begin
          commit = 1'b1;
          if (recov_clks != '0) begin
            state_d = ST_RECOV;
            cnt_d   = recov_clks;
          end else begin
            state_d = ST_IDLE;
          end
        end else if (bus_addr != wa_q) begin
          err_d = 1'b1;
        end
      end
      ST_RECOV: begin
        if (cnt_q <= CNT_W'(1)) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
    drv_d = (state_q == ST_IDLE) && !ce_s && !oe_s && we_s && !inhibit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      wa_q    <= '0;
      err_q   <= 1'b0;
      drv_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      wa_q    <= wa_d;
      err_q   <= err_d;
      drv_q   <= drv_d;
    end
  end

  assign wr_addr  = wa_q;
  assign drv_en   = drv_q;
  assign addr_err = err_q;

  // R5
  we_low_drv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_s |=> !drv_q);
  // R7
  inhibit_drv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |=> !drv_q);
  // R7
  inhibit_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |-> !commit);
  // R3
  commit_after_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(!ce_s && !we_s));
  // R6
  no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);
  // R8
  addr_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
endmodule

// File: rtl/sram_byte_array.sv
module sram_byte_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= mem[raddr];
  end
endmodule

// File: rtl/sram_bus_slave.sv
module sram_bus_slave #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_ce_n,
  input  logic              bus_oe_n,
  input  logic              bus_we_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_din,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_doe,
  input  logic              wr_inhibit,
  input  logic [CNT_W-1:0]  recov_clks,
  output logic              addr_err
);
  logic [2:0]        strb_s;
  logic              commit;
  logic              drv_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] rdata;

  sram_strobe_sync #(.N(3), .STAGES(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({bus_we_n, bus_oe_n, bus_ce_n}),
    .sync_o  (strb_s)
  );

  sram_cycle_ctl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_s       (strb_s[0]),
    .oe_s       (strb_s[1]),
    .we_s       (strb_s[2]),
    .inhibit    (wr_inhibit),
    .recov_clks (recov_clks),
    .bus_addr   (bus_addr),
    .commit     (commit),
    .wr_addr    (wr_addr),
    .drv_en     (drv_en),
    .addr_err   (addr_err)
  );

  sram_byte_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (commit),
    .waddr (wr_addr),
    .wdata (bus_din),
    .raddr (bus_addr),
    .rdata (rdata)
  );

  assign bus_doe  = drv_en;
  assign bus_dout = drv_en ? rdata : '0;

  // R1
  dout_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_doe |-> (bus_dout == '0));
endmodule

// File: tb/sram_bus_slave_tb.sv
module sram_bus_slave_tb;
  localparam int AW = 11;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ce_n, oe_n, we_n;
  logic [AW-1:0] addr;
  logic [7:0]    din;
  logic [7:0]    dout;
  logic          doe;
  logic          inhibit;
  logic [7:0]    recov;
  logic          aerr;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  sram_bus_slave #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_ce_n(ce_n), .bus_oe_n(oe_n), .bus_we_n(we_n),
    .bus_addr(addr), .bus_din(din), .bus_dout(dout), .bus_doe(doe),
    .wr_inhibit(inhibit), .recov_clks(recov), .addr_err(aerr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clk_n(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bus_idle();
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic do_write(input int a, input int d);
    addr = AW'(a); din = 8'(d); oe_n = 1'b1;
    ce_n = 1'b0; we_n = 1'b0;
    clk_n(6);
    we_n = 1'b1;
    clk_n(5);
    ce_n = 1'b1;
    clk_n(4);
  endtask

  task automatic read_chk(input int a, input int exp, input string req);
    addr = AW'(a); we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
    clk_n(6);
    chk(doe == 1'b1, req, int'(doe), 1);
    chk(dout == 8'(exp), req, int'(dout), exp);
    bus_idle();
    clk_n(4);
  endtask

  task automatic t_reset();
    // R1
    chk(doe == 1'b0, "R1", int'(doe), 0);
    chk(aerr == 1'b0, "R1", int'(aerr), 0);
    chk(dout == 8'h00, "R1", int'(dout), 0);
  endtask

  task automatic t_basic();
    // R2 R3
    do_write(16'h010, 8'hA5);
    do_write(16'h7FF, 8'h3C);
    do_write(16'h000, 8'h01);
    read_chk(16'h010, 8'hA5, "R2");
    read_chk(16'h7FF, 8'h3C, "R2");
    read_chk(16'h000, 8'h01, "R3");
  endtask

  task automatic t_late_data();
    // R3: data taken at window close
    addr = AW'(16'h020); din = 8'h33; ce_n = 1'b0; we_n = 1'b0;
    clk_n(5);
    din = 8'hC4;
    clk_n(5);
    we_n = 1'b1;
    clk_n(5);
    ce_n = 1'b1;
    clk_n(4);
    read_chk(16'h020, 8'hC4, "R3");
  endtask

  task automatic t_we_only();
    // R3: write enable without select stores nothing
    do_write(16'h030, 8'h77);
    addr = AW'(16'h030); din = 8'h99; ce_n = 1'b1; we_n = 1'b0;
    clk_n(8);
    we_n = 1'b1;
    clk_n(4);
    read_chk(16'h030, 8'h77, "R3");
  endtask

  task automatic t_ce_first();
    // R4: select rising ends window
    addr = AW'(16'h040); din = 8'h5A; ce_n = 1'b0; we_n = 1'b0;
    clk_n(6);
    ce_n = 1'b1;
    clk_n(6);
    din = 8'hFF;
    clk_n(6);
    we_n = 1'b1;
    clk_n(4);
    read_chk(16'h040, 8'h5A, "R4");
  endtask

  task automatic t_we_kills_drv();
    // R5
    do_write(16'h050, 8'h6E);
    addr = AW'(16'h050); we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
    clk_n(6);
    chk(doe == 1'b1, "R5", int'(doe), 1);
    din = 8'h6E; we_n = 1'b0;
    clk_n(4);
    chk(doe == 1'b0, "R5", int'(doe), 0);
    we_n = 1'b1;
    clk_n(6);
    bus_idle();
    clk_n(4);
    read_chk(16'h050, 8'h6E, "R5");
  endtask

  task automatic t_recovery();
    // R6
    recov = 8'd40;
    do_write(16'h060, 8'h11);
    addr = AW'(16'h060); we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
    clk_n(6);
    chk(doe == 1'b0, "R6", int'(doe), 0);
    bus_idle();
    clk_n(1);
    din = 8'h22; ce_n = 1'b0; we_n = 1'b0;
    clk_n(5);
    we_n = 1'b1;
    clk_n(2);
    ce_n = 1'b1;
    clk_n(50);
    read_chk(16'h060, 8'h11, "R6");
    recov = 8'd2;
  endtask

  task automatic t_many();
    // R9
    for (int i = 0; i < 24; i++) do_write(16'h100 + i, (i * 7 + 3) & 8'hFF);
    for (int i = 0; i < 24; i++) read_chk(16'h100 + i, (i * 7 + 3) & 8'hFF, "R9");
  endtask

  task automatic t_inhibit();
    // R7
    do_write(16'h070, 8'h42);
    inhibit = 1'b1;
    addr = AW'(16'h070); we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
    clk_n(5);
    chk(doe == 1'b0, "R7", int'(doe), 0);
    bus_idle();
    clk_n(2);
    din = 8'h99; ce_n = 1'b0; we_n = 1'b0;
    clk_n(6);
    we_n = 1'b1;
    clk_n(5);
    ce_n = 1'b1;
    clk_n(3);
    inhibit = 1'b0;
    clk_n(3);
    read_chk(16'h070, 8'h42, "R7");
    din = 8'h55; ce_n = 1'b0; we_n = 1'b0;
    clk_n(6);
    inhibit = 1'b1;
    clk_n(3);
    bus_idle();
    clk_n(5);
    inhibit = 1'b0;
    clk_n(3);
    read_chk(16'h070, 8'h42, "R7");
  endtask

  task automatic t_addr_err();
    // R8
    do_write(16'h080, 8'h10);
    chk(aerr == 1'b0, "R8", int'(aerr), 0);
    addr = AW'(16'h090); din = 8'hAB; ce_n = 1'b0; we_n = 1'b0;
    clk_n(5);
    addr = AW'(16'h080);
    clk_n(5);
    we_n = 1'b1;
    clk_n(5);
    ce_n = 1'b1;
    clk_n(4);
    chk(aerr == 1'b1, "R8", int'(aerr), 1);
    read_chk(16'h090, 8'hAB, "R8");
    read_chk(16'h080, 8'h10, "R8");
    do_write(16'h0A0, 8'h01);
    chk(aerr == 1'b1, "R8", int'(aerr), 1);
  endtask

  initial begin
    bus_idle();
    addr = '0; din = '0; inhibit = 1'b0; recov = 8'd2;
    rst_n = 1'b0;
    clk_n(3);
    rst_n = 1'b1;
    clk_n(3);
    t_reset();
    t_basic();
    t_late_data();
    t_we_only();
    t_ce_first();
    t_we_kills_drv();
    t_recovery();
    t_many();
    t_inhibit();
    t_addr_err();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule